// File: doc/BRIEF.md
# Double-Buffered DAC Code Input Front End

This block is the digital input stage of a precision digital-to-analog converter. A conversion code reaches it in one of two ways. The first is a serial bit stream sampled on the rising edges of a serial clock while chip select is low. The second is a pair of 8-bit bytes on a parallel bus. The code is assembled in an input register. A separate load strobe copies that register into the DAC latch, which drives the converter. Because the two stages are separate, several converters can receive new codes one after another and then change their outputs on a single shared strobe.

In serial mode the frame is 16 or 18 bits long and arrives either most significant bit first or least significant bit first. The bit that leaves the far end of the input register is presented on a serial output, so converters can be daisy-chained. In byte mode a configuration pin selects which byte arrives first. That first byte is held in a staging byte, and the input register changes only when the second byte is written. A clear input forces the latch to a preset code. The level of a separate pin, which also selects unipolar or bipolar operation, picks either the bottom of the range or midscale. The clear does not disturb the input register.

All inputs are taken as synchronous to `clk`. The serial clock and the load strobe are edge-detected in that clock domain.

Top module: `dac_front_end`

## Requirements
- R1: After synchronous reset, `dac_code` is 0 and `sdo` is 0, and a load with no data written also gives 0.
- R2: In serial mode (`cfg_serial`=1) with `cfg_wide`=0 and `cfg_lsb_first`=0, the 16 bits sampled on rising `sclk` edges are taken most significant bit first. After a load, `dac_code` equals that code shifted left by two.
- R3: With `cfg_lsb_first`=1 the serial frame is taken least significant bit first.
- R4: With `cfg_serial`=1 and `cfg_wide`=1, an 18-bit frame is loaded unshifted into `dac_code`. Every 16-bit code (16-bit serial or byte mode) is left-justified in `dac_code`, with bits [1:0] equal to 0.
- R5: Rising `sclk` edges while `cs_n` is high do not shift the input register.
- R6: The bit pushed out of the register by each shift appears on `sdo` at the next falling `sclk` edge, and `sdo` changes at no other time. For MSB-first frames this is bit 15 (16-bit) or bit 17 (18-bit); for LSB-first frames it is bit 0. A frame therefore leaves in the order it was sent.
- R7: In byte mode (`cfg_serial`=0) with `cfg_low_first`=0, a write with `hbe`=1 stages the high byte. A later write with `lbe`=1 places {staged, `bus`} into the input register.
- R8: With `cfg_low_first`=1, `lbe` stages the low byte and `hbe` completes the code as {`bus`, staged}.
- R9: A byte write counts only while `cs_n` is low and the block is in byte mode. Each clock cycle with an enable high counts as one write.
- R10: `dac_code` changes only on the clock edge that samples a rising `ldac`, or through the clear. Writing the input register alone leaves it unchanged.
- R11: While `clr` is high, `dac_code` shows 0 if `bip`=0 or 18'h20000 (midscale, the same for both frame lengths) if `bip`=1, without waiting for a clock edge. The latch keeps that value after `clr` falls, and `ldac` is ignored while `clr` is high.
- R12: The clear leaves the input register intact. A load after the clear restores the code written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | 1 = serial input, 0 = byte input |
| cfg_wide | input | 1 | Serial frame length: 1 = 18 bits, 0 = 16 bits |
| cfg_lsb_first | input | 1 | Serial bit order: 1 = LSB first |
| cfg_low_first | input | 1 | Byte order: 1 = low byte first |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next device in a chain |
| bus | input | 8 | Parallel byte data |
| hbe | input | 1 | High-byte write enable |
| lbe | input | 1 | Low-byte write enable |
| ldac | input | 1 | Load strobe, acts on its rising edge |
| clr | input | 1 | Clear, active high, level sensitive |
| bip | input | 1 | Clear target and bipolar select: 1 = midscale |
| dac_code | output | 18 | DAC latch code, left-justified |

## Verification
A serial bit changes the input register at the first clock edge where `sclk` is sampled high after being low. The matching `sdo` update lands at the first edge where `sclk` is sampled low again. A rising `ldac` reaches `dac_code` at the edge that samples it, and the clear acts combinationally within the same cycle. The bench changes inputs just after a falling clock edge and reads outputs at the next falling edge, half a cycle after the edge that registered the stimulus. It reads `sdo` after each bit's falling-`sclk` step. It probes the clear a nanosecond after raising `clr`, before any rising edge, so that the asynchronous path is shown apart from the registered one.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W   = 18;
    localparam int NARROW_W = 16;
    localparam int BYTE_W   = 8;
    localparam int JUST_SH  = CODE_W - NARROW_W;
    localparam int PAD_W    = CODE_W - 2 * BYTE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    typedef struct packed {
        logic       serial;
        logic       wide;
        bit_order_e order;
        logic       low_first;
    } cfg_t;

    localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);

    function automatic code_t preset_code(input logic bipolar);
        return bipolar ? MID_CODE : '0;
    endfunction

    function automatic code_t justify(input code_t raw, input logic full);
        return full ? raw : (raw << JUST_SH);
    endfunction

endpackage

// File: rtl/dacfe_edge.sv
module dacfe_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/dacfe_inreg.sv
module dacfe_inreg
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  cs_n,
    input  logic  sdi,
    input  logic  sclk_rise,
    input  logic  sclk_fall,
    input  byte_t bus,
    input  logic  hbe,
    input  logic  lbe,
    output code_t ireg,
    output logic  sdo
);
    code_t nxt;
    code_t up_v;
    code_t dn_v;
    logic  spill;
    logic  spill_q;
    byte_t stage;
    int    len;
    logic  shift_en;
    logic  byte_ok;
    logic  first_en;
    logic  second_en;
    code_t commit_v;

    assign up_v = {ireg[CODE_W-2:0], 1'b0};
    assign dn_v = {1'b0, ireg[CODE_W-1:1]};

    always_comb begin
        len = cfg.wide ? CODE_W : NARROW_W;
        nxt = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (cfg.order == ORDER_LSB) begin
                if (i == len - 1)     nxt[i] = sdi;
                else if (i < len - 1) nxt[i] = dn_v[i];
                else                  nxt[i] = 1'b0;
            end else begin
                if (i == 0)           nxt[i] = sdi;
                else if (i < len)     nxt[i] = up_v[i];
                else                  nxt[i] = 1'b0;
            end
        end
        if (cfg.order == ORDER_LSB) spill = ireg[0];
        else                        spill = cfg.wide ? ireg[CODE_W-1] : ireg[NARROW_W-1];
    end

    assign shift_en  = cfg.serial & ~cs_n & sclk_rise;
    assign byte_ok   = ~cfg.serial & ~cs_n;
    assign first_en  = cfg.low_first ? lbe : hbe;
    assign second_en = cfg.low_first ? hbe : lbe;
    assign commit_v  = cfg.low_first ? {{PAD_W{1'b0}}, bus, stage}
                                     : {{PAD_W{1'b0}}, stage, bus};

    always_ff @(posedge clk) begin
        if (rst) begin
            ireg    <= '0;
            spill_q <= 1'b0;
            stage   <= '0;
        end else if (shift_en) begin
            ireg    <= nxt;
            spill_q <= spill;
        end else if (byte_ok) begin
            if (second_en)     ireg  <= commit_v;
            else if (first_en) stage <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            sdo <= 1'b0;
        else if (sclk_fall) sdo <= spill_q;
    end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  clr,
    input  logic  bip,
    input  code_t din,
    output code_t dout
);
    code_t held;
    code_t preset;

    assign preset = preset_code(bip);

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (clr)  held <= preset;
        else if (load) held <= din;
    end

    assign dout = clr ? preset : held;
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_serial,
    input  logic              cfg_wide,
    input  logic              cfg_lsb_first,
    input  logic              cfg_low_first,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic [BYTE_W-1:0] bus,
    input  logic              hbe,
    input  logic              lbe,
    input  logic              ldac,
    input  logic              clr,
    input  logic              bip,
    output logic [CODE_W-1:0] dac_code
);
    cfg_t  cfg;
    logic  sclk_rise;
    logic  sclk_fall;
    logic  ldac_rise;
    logic  ldac_fall;
    code_t ireg;
    code_t just_v;

    assign cfg.serial    = cfg_serial;
    assign cfg.wide      = cfg_wide;
    assign cfg.order     = cfg_lsb_first ? ORDER_LSB : ORDER_MSB;
    assign cfg.low_first = cfg_low_first;

    dacfe_edge u_sclk_edge (
        .clk (clk), .rst (rst), .sig (sclk),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    dacfe_edge u_ldac_edge (
        .clk (clk), .rst (rst), .sig (ldac),
        .rise(ldac_rise), .fall(ldac_fall)
    );

    dacfe_inreg u_inreg (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .bus      (bus),
        .hbe      (hbe),
        .lbe      (lbe),
        .ireg     (ireg),
        .sdo      (sdo)
    );

    assign just_v = justify(ireg, cfg.serial & cfg.wide);

    dacfe_latch u_latch (
        .clk (clk),
        .rst (rst),
        .load(ldac_rise & ~ldac_fall),
        .clr (clr),
        .bip (bip),
        .din (just_v),
        .dout(dac_code)
    );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              bip,
    input logic              ldac,
    input logic              sclk,
    input logic              cfg_serial,
    input logic              cfg_wide,
    input logic              sdo,
    input logic [CODE_W-1:0] dac_code
);
    logic ldac_q;
    logic sclk_q;
    logic rst_q;
    logic narrow_q;
    logic ld_rise;

    assign ld_rise = ldac & ~ldac_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            ldac_q   <= 1'b0;
            sclk_q   <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            ldac_q   <= ldac;
            sclk_q   <= sclk;
            narrow_q <= ld_rise & ~clr & ~(cfg_serial & cfg_wide);
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rst_q && !clr) |-> (dac_code == '0 && sdo == 1'b0)); // R1

    AST_NARROW_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        (narrow_q && !clr) |-> (dac_code[1:0] == 2'b00)); // R4

    AST_SDO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !(!sclk && sclk_q) |=> $stable(sdo)); // R6

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld_rise) |=> (clr || $stable(dac_code))); // R10

    AST_CLEAR_TARGET: assert property (@(posedge clk) disable iff (rst)
        clr |-> (dac_code == (bip ? MID_CODE : '0))); // R11
endmodule

bind dac_front_end dacfe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .bip       (bip),
    .ldac      (ldac),
    .sclk      (sclk),
    .cfg_serial(cfg_serial),
    .cfg_wide  (cfg_wide),
    .sdo       (sdo),
    .dac_code  (dac_code)
);

// File: tb/tb_dac_front_end.sv
module tb_dac_front_end;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_serial = 1'b1, cfg_wide = 1'b0, cfg_lsb_first = 1'b0, cfg_low_first = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        sdo;
    logic [7:0]  bus = 8'h00;
    logic        hbe = 1'b0, lbe = 1'b0, ldac = 1'b0, clr = 1'b0, bip = 1'b0;
    logic [17:0] dac_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dac_front_end dut (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic sel_n);
        cs_n = sel_n; sdi = b; sclk = 1'b0; step();
        sclk = 1'b1; step();
        sclk = 1'b0; step();
    endtask

    task automatic send_frame(input logic [17:0] code, input int n, input logic lsb, input logic sel_n);
        for (int k = 0; k < n; k++)
            send_bit(lsb ? code[k] : code[n-1-k], sel_n);
        cs_n = 1'b1;
    endtask

    task automatic pulse_ldac();
        ldac = 1'b1; step();
        ldac = 1'b0; step();
    endtask

    task automatic write_byte(input logic hi, input logic [7:0] v, input logic sel_n);
        cs_n = sel_n; bus = v; hbe = hi; lbe = ~hi; step();
        hbe = 1'b0; lbe = 1'b0; cs_n = 1'b1; step();
    endtask

    task automatic t_reset();
        chk("R1 dac_code after reset", dac_code, 18'h0);
        chk("R1 sdo after reset", {17'h0, sdo}, 18'h0);
        pulse_ldac();
        chk("R1 load of empty register", dac_code, 18'h0);
    endtask

    task automatic t_serial16();
        cfg_serial = 1; cfg_wide = 0; cfg_lsb_first = 0;
        send_frame(18'h0B3C5, 16, 1'b0, 1'b0);
        chk("R10 no change before load", dac_code, 18'h0);
        pulse_ldac();
        chk("R2 msb-first 16-bit", dac_code, {16'hB3C5, 2'b00});
        cfg_lsb_first = 1;
        send_frame(18'h01E2D, 16, 1'b1, 1'b0);
        pulse_ldac();
        chk("R3 lsb-first 16-bit", dac_code, {16'h1E2D, 2'b00});
    endtask

    task automatic t_serial18();
        cfg_wide = 1; cfg_lsb_first = 0;
        send_frame(18'h2D5A7, 18, 1'b0, 1'b0);
        pulse_ldac();
        chk("R4 18-bit msb-first", dac_code, 18'h2D5A7);
        cfg_lsb_first = 1;
        send_frame(18'h1C3F1, 18, 1'b1, 1'b0);
        pulse_ldac();
        chk("R4 18-bit lsb-first", dac_code, 18'h1C3F1);
    endtask

    task automatic t_cs_gate();
        send_frame(18'h3FFFF, 18, 1'b1, 1'b1);
        pulse_ldac();
        chk("R5 shifts ignored with cs_n high", dac_code, 18'h1C3F1);
    endtask

    task automatic t_daisy();
        logic [15:0] a;
        logic [15:0] b;
        a = 16'hA5C3; b = 16'h3C96;
        cfg_wide = 0; cfg_lsb_first = 0;
        send_frame({2'b00, a}, 16, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) begin
            send_bit(b[15-k], 1'b0);
            chk("R6 sdo carries previous frame msb-first", {17'h0, sdo}, {17'h0, a[15-k]});
        end
        cs_n = 1'b1;
        pulse_ldac();
        chk("R6 second frame loaded", dac_code, {b, 2'b00});
    endtask

    task automatic t_bytes();
        cfg_serial = 0; cfg_low_first = 0;
        write_byte(1'b1, 8'h12, 1'b0);
        pulse_ldac();
        chk("R7 staged byte alone leaves code", dac_code, {16'h3C96, 2'b00});
        write_byte(1'b0, 8'h34, 1'b0);
        chk("R10 byte pair without load", dac_code, {16'h3C96, 2'b00});
        pulse_ldac();
        chk("R7 high-first pair", dac_code, {16'h1234, 2'b00});
        cfg_low_first = 1;
        write_byte(1'b0, 8'h78, 1'b0);
        write_byte(1'b1, 8'h56, 1'b0);
        pulse_ldac();
        chk("R8 low-first pair", dac_code, {16'h5678, 2'b00});
        write_byte(1'b0, 8'hEE, 1'b1);
        write_byte(1'b1, 8'hDD, 1'b1);
        pulse_ldac();
        chk("R9 byte writes ignored with cs_n high", dac_code, {16'h5678, 2'b00});
        cfg_serial = 1;
        write_byte(1'b0, 8'h11, 1'b0);
        write_byte(1'b1, 8'h22, 1'b0);
        cfg_serial = 0;
        pulse_ldac();
        chk("R9 byte writes ignored in serial mode", dac_code, {16'h5678, 2'b00});
    endtask

    task automatic t_clear();
        bip = 1'b1; clr = 1'b1; #1;
        chk("R11 midscale before any clock edge", dac_code, 18'h20000);
        step();
        ldac = 1'b1; step(); ldac = 1'b0; step();
        clr = 1'b0; step();
        chk("R11 midscale held, load ignored during clear", dac_code, 18'h20000);
        pulse_ldac();
        chk("R12 input register survives clear", dac_code, {16'h5678, 2'b00});
        bip = 1'b0; clr = 1'b1; #1;
        chk("R11 zero target", dac_code, 18'h0);
        step(); clr = 1'b0; step();
        chk("R11 zero held after clear", dac_code, 18'h0);
    endtask

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        t_reset();
        t_serial16();
        t_serial18();
        t_cs_gate();
        t_daisy();
        t_bytes();
        t_clear();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule